// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

A real-time clock core driven by a 32768 Hz clock. A prescaler divides the input clock down to one update per second. On each update the core advances a calendar held entirely in BCD: seconds, minutes, hours, day of month, month, a two-digit year and a free-running week counter. Software reaches every register over a byte-wide bus with a single write strobe and a combinational read path.

Six alarm registers hold a full date and time. The alarm fires only when every one of the six fields equals the freshly updated time; no field can be left out of the comparison. A status register reports a busy window, the running state, per-second, per-minute, per-hour and per-day update events, the alarm hit and a power-up marker. An interrupt-enable register gates the events onto a timer interrupt line and an alarm interrupt line.

Software polls the busy bit before it touches the time registers. Busy rises in the one clock cycle that precedes an update. Once busy is seen low, a full second minus one cycle remains before the next update.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the time reads 00:00:00 with day 0x01, month 0x01, year 0x00 and week 0x00. The control register (0x40) reads 0x00, the status register (0x44) reads 0x80, the interrupt-enable register (0x48) reads 0x00, and both interrupt lines are low.
- R2: Control bit 0 starts counting. While it is 0 no time register changes. While it is 1 status bit 1 reads 1, and the time advances once every PRESCALE clocks, the first update coming PRESCALE clocks after the enabling write.
- R3: Status bit 0 (busy) is 1 in exactly the one clock cycle before each update and 0 in every other cycle.
- R4: Seconds (0x00) and minutes (0x04) count in BCD from 0x00 to 0x59 and wrap to 0x00, carrying into the next field. Hours (0x08) wrap from 0x23 to 0x00 and carry into the day.
- R5: The day (0x0C) wraps to 0x01 after the last day of the month: 30 for April, June, September and November, 31 for the other months, and for February 29 when the year's value is divisible by 4, otherwise 28. Month (0x10) wraps from 0x12 to 0x01 and carries into the year (0x14), which wraps from 0x99 to 0x00.
- R6: The week register (0x18) steps by one on each day change and wraps from 6 to 0.
- R7: A write to the seconds register restarts the prescaler, so the next update comes a full PRESCALE clocks after that write.
- R8: A write that lands in the busy cycle is accepted. The written field takes the written value and the other fields advance as usual.
- R9: Status bits 2, 3, 4 and 5 are set on a second, minute, hour and day change. Each stays set until a 1 is written to it, and writing 0 to it leaves it unchanged.
- R10: The alarm registers sit at 0x20 (seconds), 0x24, 0x28, 0x2C, 0x30 and 0x34 (year). Status bit 6 sets on the update whose new time equals all six of them. A difference in any single field prevents it.
- R11: Status bit 6 (alarm) and bit 7 (power-up) each stay set until a 1 is written to that bit.
- R12: irq_timer is status bit 2 AND interrupt-enable bit 2. irq_alarm is status bit 6 AND interrupt-enable bit 3. The interrupt-enable register reads back only bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_timer | output | 1 | Per-second event interrupt |
| irq_alarm | output | 1 | Alarm match interrupt |

## Verification
The embedded assertions check on every cycle that updates are never back to back, that the seconds field stays valid BCD across an update, that no time register moves without an update or a write, that seconds stay put unless busy was seen or seconds were written, and that the alarm and per-second flags hold until they are cleared by a write of 1. Month lengths, leap Februaries, the year wrap, the alarm compare with one field deliberately off, a write landing in the busy cycle, and the prescaler restart on a seconds write depend on particular calendar values and timing. Only the bench scenarios, which check against a reference calendar computed in the bench, can show those.

// File: rtl/rtc_core_pkg.sv
`timescale 1ns/10ps
// Shared types, register offsets and BCD helpers for the calendar clock.
// Assumes every BCD byte written by software holds valid digits.
package rtc_core_pkg;

    // Calendar fields, seconds in the low byte so field index i = bits [8i+:8].
    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_date_t;

    localparam int NUM_DATE_FIELDS = 6;
    localparam logic [2:0] FLD_WEEK = 3'd6;

    localparam logic [7:0] OFS_CTRL = 8'h40;
    localparam logic [7:0] OFS_STAT = 8'h44;
    localparam logic [7:0] OFS_IEN  = 8'h48;

    // Add one to a two-digit BCD value (no range wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit BCD to binary.
    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    // Last day (BCD) of a BCD month in a BCD year.
    function automatic logic [7:0] month_last_day(input logic [7:0] mon, input logic [7:0] year);
        logic [6:0] ybin;
        ybin = bcd_to_bin(year);
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/10ps
// Divides the input clock by PRESCALE and flags the last cycle of each
// period. That cycle is both the busy window and the update strobe.
// Assumes PRESCALE >= 2. The count is held at zero while stopped, and a
// restart pulse also clears it.
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic update_due
);
    localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

    logic [CNT_W-1:0] cnt_q;

    // Period counter: clear when stopped, restarted or at end of period.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (!run || restart || cnt_q == LAST) cnt_q <= '0;
        else                                     cnt_q <= cnt_q + 1'b1;
    end

    assign update_due = run && (cnt_q == LAST);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        update_due |=> !update_due); // R3

endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/10ps
// BCD calendar registers with their next-second values. On an update the
// next values load. A bus write to one field overrides that field only.
// Assumes written values are valid BCD inside each field's range.
module rtc_calendar
    import rtc_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [2:0] wr_field,
    input  logic [7:0] wr_data,
    output rtc_date_t  cur,
    output logic [7:0] week,
    output rtc_date_t  nxt,
    output logic       ev_min,
    output logic       ev_hour,
    output logic       ev_day
);
    logic [7:0] last_day;
    logic [7:0] week_nxt;
    logic sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;

    // Next-second calendar value and carry chain.
    always_comb begin
        last_day  = month_last_day(cur.mon, cur.year);
        sec_wrap  = (cur.sec >= 8'h59);
        min_wrap  = sec_wrap  && (cur.min  >= 8'h59);
        hour_wrap = min_wrap  && (cur.hour >= 8'h23);
        day_wrap  = hour_wrap && (cur.day  >= last_day);
        mon_wrap  = day_wrap  && (cur.mon  >= 8'h12);
        nxt       = cur;
        nxt.sec   = sec_wrap ? 8'h00 : bcd_inc(cur.sec);
        if (sec_wrap)  nxt.min  = min_wrap  ? 8'h00 : bcd_inc(cur.min);
        if (min_wrap)  nxt.hour = hour_wrap ? 8'h00 : bcd_inc(cur.hour);
        if (hour_wrap) nxt.day  = day_wrap  ? 8'h01 : bcd_inc(cur.day);
        if (day_wrap)  nxt.mon  = mon_wrap  ? 8'h01 : bcd_inc(cur.mon);
        if (mon_wrap)  nxt.year = (cur.year >= 8'h99) ? 8'h00 : bcd_inc(cur.year);
        week_nxt = week;
        if (hour_wrap) week_nxt = (week >= 8'h06) ? 8'h00 : week + 8'd1;
    end

    assign ev_min  = sec_wrap;
    assign ev_hour = min_wrap;
    assign ev_day  = hour_wrap;

    // Calendar registers: update first, then a bus write wins for its field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= '{year: 8'h00, mon: 8'h01, day: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};
            week <= 8'h00;
        end else begin
            if (tick) begin
                cur  <= nxt;
                week <= week_nxt;
            end
            if (wr_en) begin
                case (wr_field)
                    3'd0:    cur.sec  <= wr_data;
                    3'd1:    cur.min  <= wr_data;
                    3'd2:    cur.hour <= wr_data;
                    3'd3:    cur.day  <= wr_data;
                    3'd4:    cur.mon  <= wr_data;
                    3'd5:    cur.year <= wr_data;
                    default: week     <= wr_data;
                endcase
            end
        end
    end

    AST_FROZEN_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(cur) && $stable(week))); // R2

    AST_SEC_STAYS_BCD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && cur.sec <= 8'h59 && cur.sec[3:0] <= 4'd9)
        |=> (cur.sec <= 8'h59 && cur.sec[3:0] <= 4'd9)); // R4

endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/10ps
// Six alarm field registers and an all-fields equality compare against a
// candidate time. Every field takes part in the compare; none can be masked.
module rtc_alarm_match
    import rtc_core_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [2:0]                        wr_field,
    input  logic [7:0]                        wr_data,
    input  logic [NUM_DATE_FIELDS-1:0][7:0]   cand,
    output logic [NUM_DATE_FIELDS-1:0][7:0]   alm,
    output logic                              hit
);
    logic [NUM_DATE_FIELDS-1:0] field_eq;

    for (genvar i = 0; i < NUM_DATE_FIELDS; i++) begin : g_field
        // One alarm field register, loaded by a bus write to its index.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   alm[i] <= 8'h00;
            else if (wr_en && wr_field == 3'(i))          alm[i] <= wr_data;
        end
        assign field_eq[i] = (alm[i] == cand[i]);
    end

    assign hit = &field_eq;

endmodule

// File: rtl/rtc_bcd_core.sv
`timescale 1ns/10ps
// BCD calendar clock core: register decode, control, status flags,
// interrupt enables and the read mux around the prescaler, calendar
// and alarm compare. Assumes a single-cycle write strobe and a
// combinational read.
module rtc_bcd_core
    import rtc_core_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_timer,
    output logic       irq_alarm
);
    logic [2:0] fld;
    logic       aligned, time_sel, alm_sel, ctrl_wr, stat_wr, ien_wr, sec_wr;
    logic       run_q, busy;
    logic [1:0] ien_q;      // [0] timer, [1] alarm
    logic [3:0] ev_q;       // [0] sec, [1] min, [2] hour, [3] day
    logic       alarm_q, pwr_q;
    logic [3:0] ev_set, ev_clr;
    logic       ev_min, ev_hour, ev_day, alm_hit;
    rtc_date_t  cur, nxt;
    logic [7:0] week;
    logic [NUM_DATE_FIELDS-1:0][7:0] alm_regs;

    // Address decode.
    assign fld      = bus_addr[4:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign time_sel = aligned && (bus_addr[7:5] == 3'b000) && (fld <= FLD_WEEK);
    assign alm_sel  = aligned && (bus_addr[7:5] == 3'b001) && (fld <= 3'd5);
    assign ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
    assign stat_wr  = bus_wr && (bus_addr == OFS_STAT);
    assign ien_wr   = bus_wr && (bus_addr == OFS_IEN);
    assign sec_wr   = bus_wr && time_sel && (fld == 3'd0);

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
        .clk(clk), .rst_n(rst_n), .run(run_q), .restart(sec_wr), .update_due(busy)
    );

    rtc_calendar u_calendar (
        .clk(clk), .rst_n(rst_n), .tick(busy),
        .wr_en(bus_wr && time_sel), .wr_field(fld), .wr_data(bus_wdata),
        .cur(cur), .week(week), .nxt(nxt),
        .ev_min(ev_min), .ev_hour(ev_hour), .ev_day(ev_day)
    );

    rtc_alarm_match u_alarm (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr && alm_sel), .wr_field(fld), .wr_data(bus_wdata),
        .cand(nxt), .alm(alm_regs), .hit(alm_hit)
    );

    // Control and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ien_q <= 2'b00;
        end else begin
            if (ctrl_wr) run_q <= bus_wdata[0];
            if (ien_wr)  ien_q <= bus_wdata[3:2];
        end
    end

    // Event set and write-one-to-clear masks.
    assign ev_set = busy ? {ev_day, ev_hour, ev_min, 1'b1} : 4'b0000;
    assign ev_clr = stat_wr ? bus_wdata[5:2] : 4'b0000;

    // Status flags: a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q    <= 4'b0000;
            alarm_q <= 1'b0;
            pwr_q   <= 1'b1;
        end else begin
            ev_q    <= (ev_q & ~ev_clr) | ev_set;
            alarm_q <= (alarm_q && !(stat_wr && bus_wdata[6])) || (busy && alm_hit);
            pwr_q   <= pwr_q && !(stat_wr && bus_wdata[7]);
        end
    end

    // Read mux.
    always_comb begin
        bus_rdata = 8'h00;
        if (time_sel) begin
            case (fld)
                3'd0:    bus_rdata = cur.sec;
                3'd1:    bus_rdata = cur.min;
                3'd2:    bus_rdata = cur.hour;
                3'd3:    bus_rdata = cur.day;
                3'd4:    bus_rdata = cur.mon;
                3'd5:    bus_rdata = cur.year;
                default: bus_rdata = week;
            endcase
        end else if (alm_sel) begin
            bus_rdata = alm_regs[fld];
        end else if (bus_addr == OFS_CTRL) begin
            bus_rdata = {7'b0, run_q};
        end else if (bus_addr == OFS_STAT) begin
            bus_rdata = {pwr_q, alarm_q, ev_q, run_q, busy};
        end else if (bus_addr == OFS_IEN) begin
            bus_rdata = {4'b0, ien_q, 2'b00};
        end
    end

    assign irq_timer = ev_q[0] && ien_q[0];
    assign irq_alarm = alarm_q && ien_q[1];

    AST_BUSY_GUARDS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sec_wr) |=> $stable(cur.sec)); // R3

    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q && !(stat_wr && bus_wdata[6])) |=> alarm_q); // R11

    AST_SEC_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q[0] && !(stat_wr && bus_wdata[2])) |=> ev_q[0]); // R9

endmodule

// File: tb/rtc_bcd_core_bench.sv
`timescale 1ns/10ps
module rtc_bcd_core_bench;
    localparam int P = 8;
    localparam logic [7:0] A_SEC = 8'h00, A_MIN = 8'h04, A_HOUR = 8'h08, A_DAY = 8'h0C,
                           A_MON = 8'h10, A_YEAR = 8'h14, A_WEEK = 8'h18, A_ALM = 8'h20,
                           A_CTRL = 8'h40, A_STAT = 8'h44, A_IEN = 8'h48;

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic irq_timer, irq_alarm;

    int n_checks = 0, n_fail = 0;
    int ms, mm, mh, md, mo, my, mw, exp_ev;

    rtc_bcd_core #(.PRESCALE(P)) u_rtc_bcd_core (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_timer(irq_timer), .irq_alarm(irq_alarm)
    );

    always #2 clk = ~clk;

    function automatic int bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int dim(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        bus_addr = a;
        #0.1;
        d = int'(bus_rdata);
    endtask

    task automatic model_adv();
        exp_ev |= 1; ms++;
        if (ms == 60) begin
            ms = 0; exp_ev |= 2; mm++;
            if (mm == 60) begin
                mm = 0; exp_ev |= 4; mh++;
                if (mh == 24) begin
                    mh = 0; exp_ev |= 8; mw = (mw + 1) % 7; md++;
                    if (md > dim(mo, my)) begin
                        md = 1; mo++;
                        if (mo == 13) begin mo = 1; my = (my + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic load_time(input int s, input int m, input int h, input int d,
                             input int o, input int y, input int w);
        ms = s; mm = m; mh = h; md = d; mo = o; my = y; mw = w;
        wr(A_SEC, 8'(bcd(s)));  wr(A_MIN, 8'(bcd(m)));  wr(A_HOUR, 8'(bcd(h)));
        wr(A_DAY, 8'(bcd(d)));  wr(A_MON, 8'(bcd(o)));  wr(A_YEAR, 8'(bcd(y)));
        wr(A_WEEK, 8'(w));
    endtask

    task automatic check_time(input string req);
        int v;
        rd(A_SEC, v);  check({req, " sec"}, v, bcd(ms));
        rd(A_MIN, v);  check({req, " min"}, v, bcd(mm));
        rd(A_HOUR, v); check({req, " hour"}, v, bcd(mh));
        rd(A_DAY, v);  check({req, " day"}, v, bcd(md));
        rd(A_MON, v);  check({req, " month"}, v, bcd(mo));
        rd(A_YEAR, v); check({req, " year"}, v, bcd(my));
        rd(A_WEEK, v); check({req, " week"}, v, mw);
    endtask

    // Waits for busy, checks its distance from the current cycle, then the update.
    task automatic wait_tick(input bit chk_period, input string req);
        int n, st;
        n = 1;
        rd(A_STAT, st);
        while ((st & 1) == 0) begin
            @(negedge clk); n++;
            rd(A_STAT, st);
        end
        if (chk_period) check({req, " cycles to busy"}, n, P);
        @(negedge clk);
        model_adv();
        rd(A_STAT, st);
        check("R3 busy low after update", st & 1, 0);
        check("R9 event flags", (st >> 2) & 15, exp_ev);
    endtask

    task automatic set_alarm(input int tweak);
        int b[6];
        int sv[8];
        sv = '{ms, mm, mh, md, mo, my, mw, exp_ev};
        model_adv();
        b = '{ms, mm, mh, md, mo, my};
        ms = sv[0]; mm = sv[1]; mh = sv[2]; md = sv[3];
        mo = sv[4]; my = sv[5]; mw = sv[6]; exp_ev = sv[7];
        case (tweak)
            0: b[0] = (b[0] + 1) % 60;
            1: b[1] = (b[1] + 1) % 60;
            2: b[2] = (b[2] + 1) % 24;
            3: b[3] = (b[3] == 1) ? 2 : 1;
            4: b[4] = (b[4] == 1) ? 2 : 1;
            5: b[5] = (b[5] + 1) % 100;
            default: ;
        endcase
        for (int k = 0; k < 6; k++) wr(A_ALM + 8'(4 * k), 8'(bcd(b[k])));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog R3: actual no completion expected completion");
        finish_run();
    end

    initial begin
        int v, tw, y, o, d, h, m, s, w;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ms = 0; mm = 0; mh = 0; md = 1; mo = 1; my = 0; mw = 0; exp_ev = 0;

        // R1 reset state
        check_time("R1");
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_STAT, v); check("R1 status", v, 8'h80);
        rd(A_IEN, v);  check("R1 ien", v, 0);
        check("R1 irq_timer", irq_timer, 0);
        check("R1 irq_alarm", irq_alarm, 0);

        // R2 stopped clock does not advance
        repeat (3 * P) @(negedge clk);
        rd(A_SEC, v); check("R2 frozen sec", v, 0);

        // R4 R5 R6 end of February in a non-leap year
        load_time(58, 59, 23, 28, 2, 23, 6);
        wr(A_CTRL, 8'h01);
        rd(A_CTRL, v); check("R2 ctrl run", v, 1);
        rd(A_STAT, v); check("R2 status run", (v >> 1) & 1, 1);
        wait_tick(1, "R2");
        check_time("R4");
        wait_tick(1, "R3");
        check_time("R5/R6 month end");
        check("R12 timer gated off", irq_timer, 0);

        // R9 R11 write-one-to-clear behaviour
        wr(A_CTRL, 8'h00);
        wr(A_STAT, 8'h00);
        rd(A_STAT, v); check("R9 write 0 keeps events", (v >> 2) & 15, 15);
        wr(A_STAT, 8'h3C); exp_ev = 0;
        rd(A_STAT, v); check("R9 events cleared", (v >> 2) & 15, 0);
        check("R11 power-up kept", (v >> 7) & 1, 1);
        wr(A_STAT, 8'h80);
        rd(A_STAT, v); check("R11 power-up cleared", (v >> 7) & 1, 0);

        // R5 leap February and year wrap
        load_time(59, 59, 23, 28, 2, 24, 2);
        wr(A_CTRL, 8'h01);
        wait_tick(1, "R2");
        check_time("R5 leap");
        wr(A_CTRL, 8'h00);
        load_time(59, 59, 23, 31, 12, 99, 3);
        wr(A_CTRL, 8'h01);
        wait_tick(1, "R2");
        check_time("R5 year wrap");

        // R7 seconds write restarts the prescaler
        repeat (3) @(negedge clk);
        wr(A_SEC, 8'h10); ms = 10;
        wait_tick(1, "R7");
        check_time("R7");

        // R8 write landing in the busy cycle
        rd(A_STAT, v);
        while ((v & 1) == 0) begin @(negedge clk); rd(A_STAT, v); end
        bus_addr = A_MIN; bus_wdata = 8'h42; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_adv(); mm = 42;
        check_time("R8");

        // R10 R11 R12 directed alarm match
        wr(A_CTRL, 8'h00);
        wr(A_STAT, 8'h7C); exp_ev = 0;
        load_time(15, 30, 12, 15, 6, 30, 1);
        set_alarm(-1);
        wr(A_IEN, 8'h0C);
        wr(A_CTRL, 8'h01);
        wait_tick(1, "R10");
        rd(A_STAT, v); check("R10 alarm set", (v >> 6) & 1, 1);
        check("R12 irq_alarm", irq_alarm, 1);
        check("R12 irq_timer", irq_timer, 1);
        wr(A_IEN, 8'h08);
        check("R12 timer disabled", irq_timer, 0);
        wr(A_STAT, 8'h40);
        rd(A_STAT, v); check("R11 alarm cleared", (v >> 6) & 1, 0);
        check("R11 irq_alarm low", irq_alarm, 0);
        wr(A_IEN, 8'hFF);
        rd(A_IEN, v); check("R12 ien readback", v, 8'h0C);

        // Random rollover-heavy times with matching or near-miss alarms
        for (int it = 0; it < 24; it++) begin
            wr(A_CTRL, 8'h00);
            wr(A_STAT, 8'h7C); exp_ev = 0;
            y = int'($urandom % 100);
            o = 1 + int'($urandom % 12);
            d = ($urandom % 2 == 1) ? dim(o, y) : 1 + int'($urandom % 32'(dim(o, y)));
            h = ($urandom % 2 == 1) ? 23 : int'($urandom % 24);
            m = ($urandom % 2 == 1) ? 59 : int'($urandom % 60);
            s = ($urandom % 3 != 0) ? 59 : int'($urandom % 60);
            w = int'($urandom % 7);
            load_time(s, m, h, d, o, y, w);
            tw = ($urandom % 2 == 1) ? -1 : int'($urandom % 6);
            set_alarm(tw);
            wr(A_IEN, 8'h08);
            wr(A_CTRL, 8'h01);
            wait_tick(1, "R2");
            check_time("R4/R5/R6 random");
            rd(A_STAT, v); check("R10 random alarm", (v >> 6) & 1, (tw < 0) ? 1 : 0);
            check("R12 random irq_alarm", irq_alarm, (tw < 0) ? 1 : 0);
        end

        finish_run();
    end

endmodule